// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Controller

This block collects 64 interrupt inputs and steers each one to one of eight outputs: a normal interrupt line (IRQ), a fast interrupt line (FIQ) and six auxiliary lines. Every source has its own 8-bit control byte. The byte turns the source on or off, chooses how the source triggers (active-high level, rising edge or falling edge) and chooses which output it drives. Each input goes through a two-flop synchronizer. Edge events are latched until software clears them. Level sources show their synchronized input directly.

Software reaches the block through a simple register port. The port takes a 6-bit word address (byte offset = 4 × word address) and byte-lane enables. Reads return data in the cycle after the read strobe.

For IRQ and for FIQ, a priority register reports the number of the winning source and a valid flag. Under fixed priority, the lowest-numbered pending source wins. When rotating priority is on, reading the register makes the winner just read the lowest priority. The next search then starts at the number that follows it.

Top module: `rotvic`

## Requirements
- R1: After reset, every control byte, both status words and both priority registers read 0, and all eight outputs are low.
- R2: The control byte of source n is byte lane n mod 4 of word 16 + n/4 (byte offset 0x40 + n). A write changes only the lanes whose byte enable is set, and reads return all eight bits written.
- R3: A source whose control bits 6:5 are both 0 is an active-high level source. Its status bit follows its input, and writing 1 to that status bit has no effect.
- R4: Control bit 5 selects rising-edge capture. The status bit stays set after the input falls, writing 0 leaves it set, and writing 1 clears it.
- R5: Control bit 6 selects falling-edge capture. A rising edge alone does not set the status bit of such a source.
- R6: Control bit 3 is the enable. A disabled source still shows in status but drives no output.
- R7: Control bits 2:0 select the destination: code 0 is IRQ, code 1 is FIQ, and codes 2 to 7 are auxiliary outputs 0 to 5. Each output is the OR of the enabled pending sources routed to it.
- R8: A read of word 8 (offset 0x20) returns the IRQ winner in bits 5:0, the rotate enable in bit 6 and a valid flag in bit 7. Under fixed priority the lowest-numbered pending source wins. When nothing routed to IRQ is pending, bit 7 is 0.
- R9: Writing bit 6 of the priority register turns on rotation, and bits 5:0 load the last-served source. Each read that sees a valid winner makes that winner the lowest priority, and the search wraps past 63 to 0.
- R10: Word 9 (offset 0x24) is the FIQ priority register. It behaves like R8/R9 for FIQ-routed sources, independently of IRQ.
- R11: A level source reaches its output two clock edges after its input changes. An edge source's output rises on the third edge.
- R12: Status words are word 32 (sources 0–31, offset 0x80) and word 33 (sources 32–63, offset 0x84). Bit k of a status word is source 32·w + k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| waddr | input | 6 | Word address (byte offset / 4) |
| be | input | 4 | Byte-lane enables for writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| src_in | input | 64 | Interrupt source inputs |
| irq_o | output | 1 | IRQ output |
| fiq_o | output | 1 | FIQ output |
| aux_o | output | 6 | Auxiliary destination outputs |

## Verification
A level input reaches the status bit and the outputs after two rising edges, and an edge input after three. The bench drives each input at a falling edge. It then samples the outputs at falling edges exactly one cycle before and at the due cycle, so that a wrong pipeline depth is caught. Register writes take effect at the next rising edge. Read data is registered at the edge that follows the strobe, and the bench samples it at the falling edge after that edge. A rotation step is due at that same edge, so successive reads each see the previous step.

// File: rtl/rotvic.sv
module rotvic #(
  parameter int NSRC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  waddr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [63:0] src_in,
  output logic        irq_o,
  output logic        fiq_o,
  output logic [5:0]  aux_o
);
  localparam int IW = $clog2(NSRC);

  logic [7:0]      ctl [NSRC];
  logic [NSRC-1:0] s1, s2, s3, lat, pend, act, irq_vec, fiq_vec, set_v, clr_v;
  logic            irq_rot, fiq_rot;
  logic [IW-1:0]   irq_last, fiq_last;
  logic [IW:0]     irq_pick, fiq_pick;
  logic [31:0]     rd_mux;
  logic [5:0]      cbase;

  function automatic logic [IW:0] pick(input logic [NSRC-1:0] v, input logic [IW-1:0] start);
    logic [NSRC-1:0] d;
    logic [IW:0]     r;
    d = NSRC'({v, v} >> start);
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (d[i]) r = {1'b1, IW'(i) + start};
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= src_in; s2 <= s1; s3 <= s2;
    end
  end

  always_comb begin
    aux_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      pend[i]    = (ctl[i][6:5] == 2'b00) ? s2[i] : lat[i];
      act[i]     = pend[i] & ctl[i][3];
      irq_vec[i] = act[i] && ctl[i][2:0] == 3'd0;
      fiq_vec[i] = act[i] && ctl[i][2:0] == 3'd1;
      if (act[i] && ctl[i][2:0] >= 3'd2) aux_o[3'(ctl[i][2:0] - 3'd2)] = 1'b1;
      set_v[i] = (ctl[i][5] & s2[i] & ~s3[i]) | (ctl[i][6] & ~s2[i] & s3[i]);
      clr_v[i] = wr_en && waddr == 6'(32 + i / 32) && be[(i % 32) / 8] && wdata[i % 32];
    end
  end

  assign irq_o    = |irq_vec;
  assign fiq_o    = |fiq_vec;
  assign irq_pick = pick(irq_vec, irq_rot ? irq_last + 1'b1 : '0);
  assign fiq_pick = pick(fiq_vec, fiq_rot ? fiq_last + 1'b1 : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) lat <= '0;
    else        lat <= set_v | (lat & ~clr_v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) ctl[i] <= '0;
    end else if (wr_en && waddr[5:4] == 2'b01) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) ctl[{waddr[3:0], 2'(b)}] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_rot <= 1'b0; irq_last <= '0;
      fiq_rot <= 1'b0; fiq_last <= '0;
    end else begin
      if (wr_en && waddr == 6'd8 && be[0]) begin
        irq_rot <= wdata[6]; irq_last <= wdata[IW-1:0];
      end else if (rd_en && waddr == 6'd8 && irq_rot && irq_pick[IW]) begin
        irq_last <= irq_pick[IW-1:0];
      end
      if (wr_en && waddr == 6'd9 && be[0]) begin
        fiq_rot <= wdata[6]; fiq_last <= wdata[IW-1:0];
      end else if (rd_en && waddr == 6'd9 && fiq_rot && fiq_pick[IW]) begin
        fiq_last <= fiq_pick[IW-1:0];
      end
    end
  end

  assign cbase = {waddr[3:0], 2'b00};

  always_comb begin
    if (waddr[5:4] == 2'b01)
      rd_mux = {ctl[cbase + 6'd3], ctl[cbase + 6'd2], ctl[cbase + 6'd1], ctl[cbase]};
    else begin
      case (waddr)
        6'd8:    rd_mux = {24'd0, irq_pick[IW], irq_rot, irq_pick[IW-1:0]};
        6'd9:    rd_mux = {24'd0, fiq_pick[IW], fiq_rot, fiq_pick[IW-1:0]};
        6'd32:   rd_mux = pend[31:0];
        6'd33:   rd_mux = pend[63:32];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

module rotvic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [5:0]  waddr,
  input logic [63:0] lat,
  input logic [63:0] irq_vec,
  input logic [63:0] fiq_vec,
  input logic [6:0]  irq_pick,
  input logic [6:0]  fiq_pick,
  input logic        irq_rot,
  input logic        irq_o,
  input logic        fiq_o
);
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && waddr[5:1] == 5'b10000) |=> ((lat & $past(lat)) == $past(lat)));

  a_r8_valid_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == irq_pick[6]);

  a_r8_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pick[6] |-> irq_vec[irq_pick[5:0]]);

  a_r8_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_rot && irq_pick[6]) |-> ((irq_vec & ((64'd1 << irq_pick[5:0]) - 64'd1)) == 64'd0));

  a_r10_fiq_winner: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == fiq_pick[6] && (!fiq_pick[6] || fiq_vec[fiq_pick[5:0]]));

  a_r7_one_destination: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & fiq_vec) == 64'd0);
endmodule

bind rotvic rotvic_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .lat(lat),
  .irq_vec(irq_vec), .fiq_vec(fiq_vec), .irq_pick(irq_pick), .fiq_pick(fiq_pick),
  .irq_rot(irq_rot), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/rotvic_test.sv
module rotvic_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  waddr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_in = '0;
  logic        irq_o, fiq_o;
  logic [5:0]  aux_o;
  int ntest = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rotvic uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .waddr(waddr),
              .be(be), .wdata(wdata), .rdata(rdata), .src_in(src_in),
              .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    src_in = '0; rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; waddr = a;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic setctl(input int s, input logic [7:0] v);
    wr(6'(16 + s / 4), 4'(1 << (s % 4)), 32'(v) << (8 * (s % 4)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(6'd16, d); chk("R1 ctl word", d, 0);
    rd(6'd31, d); chk("R1 last ctl word", d, 0);
    rd(6'd32, d); chk("R1 status lo", d, 0);
    rd(6'd33, d); chk("R1 status hi", d, 0);
    rd(6'd8, d);  chk("R1 irq prio", d, 0);
    rd(6'd9, d);  chk("R1 fiq prio", d, 0);
    chk("R1 outputs", {24'd0, aux_o, fiq_o, irq_o}, 0);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    do_reset();
    wr(6'd17, 4'b0101, 32'hA1B2C3D4);
    rd(6'd17, d); chk("R2 lane enables", d, 32'h00B200D4);
    wr(6'd17, 4'b1000, 32'hFF000000);
    rd(6'd17, d); chk("R2 lane 3 full byte", d, 32'hFFB200D4);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    setctl(5, 8'h08);
    src_in[5] = 1'b1;
    tick(1); chk("R11 level not yet", 32'(irq_o), 0);
    tick(1); chk("R11 level after two edges", 32'(irq_o), 1);
    rd(6'd32, d); chk("R12 status bit 5", d, 32'h20);
    wr(6'd32, 4'hF, 32'h20);
    rd(6'd32, d); chk("R3 level ignores clear", d, 32'h20);
    chk("R3 irq still high", 32'(irq_o), 1);
    src_in[5] = 1'b0;
    tick(3);
    rd(6'd32, d); chk("R3 level follows input low", d, 0);
    chk("R3 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    do_reset();
    setctl(40, 8'h29);
    src_in[40] = 1'b1;
    tick(2); chk("R11 edge not yet", 32'(fiq_o), 0);
    tick(1); chk("R11 edge on third edge", 32'(fiq_o), 1);
    src_in[40] = 1'b0;
    tick(4);
    rd(6'd33, d); chk("R4 latched after fall", d, 32'h100);
    wr(6'd33, 4'hF, 32'h0);
    rd(6'd33, d); chk("R4 write 0 no effect", d, 32'h100);
    wr(6'd33, 4'hF, 32'h100);
    rd(6'd33, d); chk("R4 write 1 clears", d, 0);
    chk("R4 fiq low after clear", 32'(fiq_o), 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    do_reset();
    setctl(12, 8'h48);
    src_in[12] = 1'b1;
    tick(4);
    rd(6'd32, d); chk("R5 rising ignored", d, 0);
    src_in[12] = 1'b0;
    tick(4);
    rd(6'd32, d); chk("R5 falling captured", d, 32'h1000);
    chk("R5 irq high", 32'(irq_o), 1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    setctl(20, 8'h00);
    src_in[20] = 1'b1;
    tick(3);
    rd(6'd32, d); chk("R6 status while disabled", d, 32'h100000);
    chk("R6 disabled no output", 32'(irq_o), 0);
    setctl(20, 8'h08);
    chk("R6 enabled drives irq", 32'(irq_o), 1);
  endtask

  task automatic t_dest();
    do_reset();
    src_in[33] = 1'b1;
    tick(3);
    for (int c = 0; c < 8; c++) begin
      setctl(33, 8'(8 | c));
      chk($sformatf("R7 dest code %0d", c), {24'd0, aux_o, fiq_o, irq_o}, 32'(1 << c));
    end
  endtask

  task automatic t_prio();
    logic [31:0] d;
    do_reset();
    setctl(3, 8'h08); setctl(10, 8'h08); setctl(50, 8'h08); setctl(60, 8'h09);
    src_in[3] = 1'b1; src_in[10] = 1'b1; src_in[50] = 1'b1;
    tick(3);
    rd(6'd8, d); chk("R8 fixed lowest wins", d, 32'h83);
    rd(6'd8, d); chk("R8 fixed does not move", d, 32'h83);
    rd(6'd9, d); chk("R10 fiq none valid clear", d, 32'h00);
    src_in[60] = 1'b1;
    tick(3);
    rd(6'd9, d); chk("R10 fiq winner 60", d, 32'hBC);
    wr(6'd8, 4'h1, 32'h40);
    rd(6'd8, d); chk("R9 rotate first", d, 32'hC3);
    rd(6'd8, d); chk("R9 rotate second", d, 32'hCA);
    rd(6'd8, d); chk("R9 rotate third", d, 32'hF2);
    rd(6'd8, d); chk("R9 rotate wraps", d, 32'hC3);
    rd(6'd9, d); chk("R10 fiq unaffected", d, 32'hBC);
    wr(6'd8, 4'h1, 32'h00);
    src_in[3] = 1'b0;
    tick(3);
    rd(6'd8, d); chk("R8 next lowest", d, 32'h8A);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      ntest++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bytes();
    t_level();
    t_rise();
    t_fall();
    t_enable();
    t_dest();
    t_prio();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule